// File: doc/BRIEF.md
# Half-Duplex Command/Response Serial Frame Master

This block is the master side of a three-wire half-duplex serial link in which every frame is a short conversation. The master first sends an 8-bit control word, then leaves the data line alone for one turnaround bit, and then clocks in an N-bit response from the selected device. A frame is therefore 9+N bits long, and N can be set from 4 to 23. The block drives the serial clock, an active-low select and an output enable for the shared data pad, and it samples the serial input.

A client offers one packed frame word at a time through a valid/ready pair. The control field sits in the upper eight bits of that word and the lower N+1 bits are ignored. When the frame completes, the block returns a word of the same width. It holds the turnaround sample just above the response bits and zeros in the control field, and a one-cycle strobe marks it. If the next word is already offered when a frame ends, the next frame starts on the very next bit period and the select stays low. If no word is waiting, the select is released one bit period later.

Top module: `mw_frame_master`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) ss_n is 1, sclk, oe, sdo and rsp_valid are 0, and req_ready is 1.
- R2: A frame lasts FRAME_BITS = RESP_BITS+9 bit periods of 2*HALF_DIV clocks each. sclk is low for the first HALF_DIV clocks of each bit and high for the rest. The first rising edge comes HALF_DIV clocks after ss_n falls, and sclk is low whenever ss_n is high.
- R3: Bits 0..7 of a frame carry req_word[RESP_BITS+8:RESP_BITS+1], most significant bit first, and sdo changes only where sclk falls.
- R4: req_word[RESP_BITS:0] has no effect on the line: sdo is 0 from the turnaround bit to the end of the frame.
- R5: sdi is not captured during the eight control bits: rsp_word[FRAME_BITS-1:RESP_BITS+1] is always 0.
- R6: sdi is sampled on each rising sclk edge. rsp_word[RESP_BITS] holds the sample from the turnaround bit (bit 8), and rsp_word[RESP_BITS-1:0] holds the response bits, first received in the most significant position.
- R7: oe is 1 from the clock in which ss_n falls through the end of the control word, and it is 0 from the falling edge that starts bit 8 until the next frame.
- R8: rsp_valid is high for exactly one clock per frame, in the clock in which sclk falls at the end of the frame's last bit, and responses appear in request order.
- R9: If req_valid is high when the last bit of a frame ends, the next frame starts with no gap. ss_n stays low, the bit period does not change, and oe is 1 again for the new control word.
- R10: With no request pending at the end of a frame, ss_n rises 2*HALF_DIV clocks after the rsp_valid clock. req_ready is 1 only while idle or in the clock that ends a frame's last bit.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A frame word is offered |
| req_word | input | FRAME_BITS | Packed frame: control in the top eight bits, the rest ignored |
| req_ready | output | 1 | The offered word is taken at this clock edge |
| rsp_valid | output | 1 | One-cycle strobe: rsp_word is new |
| rsp_word | output | FRAME_BITS | Zeros, turnaround sample, then the response bits |
| sclk | output | 1 | Serial clock, idles low |
| ss_n | output | 1 | Device select, active low |
| oe | output | 1 | Output enable for the shared data pad |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench acts as the serial device. It checks every bit on the line and answers each frame with a computed response. Single frames with all-zero, all-one and alternating control and response fields separate a reversed bit order from a shift that is one bit off. A 256-frame back-to-back burst sweeps every control value while the data line toggles during control bits. That burst shows whether control-phase noise leaks into the reply, whether the bit period or the select breaks at frame seams, and whether the ignored low field ever reaches the line. A short burst at the end checks that the select is released on time after a chain of frames as well as after a single frame.

// File: rtl/mw_pkg.sv
// Package: shared constants, state type and frame-size helper for the
// half-duplex command/response serial master.
package mw_pkg;

    // Width of the outgoing control word at the head of every frame
    localparam int MW_CMD_BITS = 8;

    // Controller sequencing states
    typedef enum logic [1:0] {
        MW_IDLE  = 2'd0,   // select released, waiting for a request
        MW_SHIFT = 2'd1,   // serial clock running, frame bits moving
        MW_TAIL  = 2'd2    // last frame done, select held one bit period
    } mw_state_e;

    // Total frame length for a given response length
    function automatic int mw_frame_bits(input int resp_bits);
        return resp_bits + MW_CMD_BITS + 1;
    endfunction

endpackage

// File: rtl/mw_sclk_gen.sv
// Module: serial clock generator.
// Produces a low-first serial clock with a half period of HALF_DIV system
// clocks while run is high, and one-cycle strobes marking the system clock
// edge on which sclk will rise or fall.
// Assumes: run drops only at a falling strobe or while sclk is low; the
// output is forced low and the phase counter cleared while run is low.
module mw_sclk_gen #(
    parameter int HALF_DIV = 2,
    localparam int CW = $clog2(HALF_DIV + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_stb,
    output logic fall_stb
);

    logic [CW-1:0] ph_cnt;
    logic          ph_end;

    // End of the current half period
    assign ph_end   = run && (ph_cnt == CW'(HALF_DIV - 1));
    assign rise_stb = ph_end && !sclk;
    assign fall_stb = ph_end &&  sclk;

    // Half-period counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_cnt <= '0;
            sclk   <= 1'b0;
        end else if (!run) begin
            ph_cnt <= '0;
            sclk   <= 1'b0;
        end else if (ph_end) begin
            ph_cnt <= '0;
            sclk   <= ~sclk;
        end else begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mw_cmd_ser.sv
// Module: control-word serializer.
// Loads the control field of a packed frame word and presents it on sdo
// most significant bit first, advancing one bit per falling strobe. After
// eight shifts the register holds zeros, so the line is quiet for the
// turnaround and response phases without extra gating.
// Assumes: load and shift may coincide; load wins.
module mw_cmd_ser #(
    parameter int RESP_BITS = 8,
    localparam int FRAME_BITS = mw_pkg::mw_frame_bits(RESP_BITS),
    localparam int CMD_BITS   = mw_pkg::MW_CMD_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  shift,
    input  logic [FRAME_BITS-1:0] word,
    output logic                  sdo
);

    logic [CMD_BITS-1:0] cmd_q;

    assign sdo = cmd_q[CMD_BITS-1];

    // Load the control field or advance by one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (load) begin
            cmd_q <= word[FRAME_BITS-1 -: CMD_BITS];
        end else if (shift) begin
            cmd_q <= {cmd_q[CMD_BITS-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/mw_resp_cap.sv
// Module: response capture.
// Shifts sdi in on every rising strobe that the controller marks as a
// capture bit (turnaround plus response), then publishes the collected
// bits, with the control field zeroed, as a registered output word.
// Assumes: clear and publish may coincide; publish sees the old bits.
module mw_resp_cap #(
    parameter int RESP_BITS = 8,
    localparam int FRAME_BITS = mw_pkg::mw_frame_bits(RESP_BITS),
    localparam int CAP_BITS   = RESP_BITS + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  sample,
    input  logic                  publish,
    input  logic                  sdi,
    output logic [FRAME_BITS-1:0] word
);

    logic [CAP_BITS-1:0] cap_q;

    // Collect turnaround and response bits, first bit ends up on top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (clear) begin
            cap_q <= '0;
        end else if (sample) begin
            cap_q <= {cap_q[CAP_BITS-2:0], sdi};
        end
    end

    // Publish the finished frame with the control field cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (publish) begin
            word <= {{(FRAME_BITS-CAP_BITS){1'b0}}, cap_q};
        end
    end

endmodule

// File: rtl/mw_frame_master.sv
// Module: half-duplex command/response serial frame master (top).
// Sequences frames of 8 control bits, one turnaround bit and RESP_BITS
// response bits. Drives select, output enable, clock and data, and chains
// frames without releasing the select when the next request is already
// waiting at the end of a frame.
// Assumes: HALF_DIV >= 1, RESP_BITS in 4..23; req_word is held stable
// while req_valid is high and req_ready is low.
module mw_frame_master #(
    parameter int RESP_BITS = 8,
    parameter int HALF_DIV  = 2,
    localparam int FRAME_BITS = mw_pkg::mw_frame_bits(RESP_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [FRAME_BITS-1:0] req_word,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic [FRAME_BITS-1:0] rsp_word,
    output logic                  sclk,
    output logic                  ss_n,
    output logic                  oe,
    output logic                  sdo,
    input  logic                  sdi
);
    import mw_pkg::*;

    localparam int BIT_W   = $clog2(FRAME_BITS + 1);
    localparam int TAIL_N  = 2 * HALF_DIV;
    localparam int TAIL_W  = $clog2(TAIL_N + 1);

    mw_state_e      state;
    logic [BIT_W-1:0]  bit_idx;
    logic [TAIL_W-1:0] tail_cnt;
    logic           run;
    logic           rise_stb;
    logic           fall_stb;
    logic           last_fall;
    logic           accept;
    logic           cap_bit;

    assign run       = (state == MW_SHIFT);
    assign last_fall = fall_stb && (bit_idx == BIT_W'(FRAME_BITS - 1));
    assign req_ready = (state == MW_IDLE) || last_fall;
    assign accept    = req_valid && req_ready;
    assign cap_bit   = (bit_idx >= BIT_W'(MW_CMD_BITS));

    mw_sclk_gen #(.HALF_DIV(HALF_DIV)) clk_gen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sclk     (sclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mw_cmd_ser #(.RESP_BITS(RESP_BITS)) cmd_ser_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .shift (fall_stb),
        .word  (req_word),
        .sdo   (sdo)
    );

    mw_resp_cap #(.RESP_BITS(RESP_BITS)) resp_cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .sample  (rise_stb && cap_bit),
        .publish (last_fall),
        .sdi     (sdi),
        .word    (rsp_word)
    );

    // Frame sequencer: select, output enable, bit position and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= MW_IDLE;
            bit_idx   <= '0;
            tail_cnt  <= '0;
            ss_n      <= 1'b1;
            oe        <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                MW_IDLE: begin
                    if (req_valid) begin
                        state   <= MW_SHIFT;
                        bit_idx <= '0;
                        ss_n    <= 1'b0;
                        oe      <= 1'b1;
                    end
                end
                MW_SHIFT: begin
                    if (last_fall) begin
                        rsp_valid <= 1'b1;
                        bit_idx   <= '0;
                        if (req_valid) begin
                            oe <= 1'b1;
                        end else begin
                            state    <= MW_TAIL;
                            tail_cnt <= '0;
                            oe       <= 1'b0;
                        end
                    end else if (fall_stb) begin
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == BIT_W'(MW_CMD_BITS - 1)) begin
                            oe <= 1'b0;
                        end
                    end
                end
                MW_TAIL: begin
                    if (tail_cnt == TAIL_W'(TAIL_N - 1)) begin
                        ss_n  <= 1'b1;
                        state <= MW_IDLE;
                    end else begin
                        tail_cnt <= tail_cnt + 1'b1;
                    end
                end
                default: begin
                    state <= MW_IDLE;
                    ss_n  <= 1'b1;
                    oe    <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/mw_frame_master_chk.sv
// Module: property checker for the frame master, attached by bind.
// Watches only the top-level ports and relates them over time.
module mw_frame_master_chk #(
    parameter int RESP_BITS = 8,
    parameter int HALF_DIV  = 2,
    localparam int FRAME_BITS = mw_pkg::mw_frame_bits(RESP_BITS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rsp_valid,
    input logic [FRAME_BITS-1:0] rsp_word,
    input logic                  sclk,
    input logic                  ss_n,
    input logic                  oe,
    input logic                  sdo
);

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sclk); // R2

    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !ss_n); // R7

    AST_OE_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) |-> (oe && !sclk)); // R7

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !sdo); // R4

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8

    AST_RSP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_word >> (RESP_BITS + 1)) == '0)); // R5

endmodule

bind mw_frame_master mw_frame_master_chk #(
    .RESP_BITS (RESP_BITS),
    .HALF_DIV  (HALF_DIV)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .rsp_word  (rsp_word),
    .sclk      (sclk),
    .ss_n      (ss_n),
    .oe        (oe),
    .sdo       (sdo)
);

// File: tb/mw_frame_master_tb.sv
`timescale 1ns/100ps
// Bench: acts as the serial device, sweeps control words and responses,
// and checks every line bit, every response word and select timing.
module mw_frame_master_tb_top;
    localparam int N    = 8;
    localparam int HALF = 2;
    localparam int W    = N + 9;
    localparam int MAXF = 512;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [W-1:0] req_word = '0;
    logic         req_ready;
    logic         rsp_valid;
    logic [W-1:0] rsp_word;
    logic         sclk, ss_n, oe, sdo;
    logic         sdi = 1'b0;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int nsent = 0;
    int ss_rises = 0;
    logic [7:0]   ctrl_a [MAXF];
    logic [N-1:0] data_a [MAXF];
    logic         turn_a [MAXF];

    always #2.5 clk = ~clk;

    mw_frame_master #(.RESP_BITS(N), .HALF_DIV(HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .sclk(sclk), .ss_n(ss_n), .oe(oe), .sdo(sdo), .sdi(sdi)
    );

    // Record one check
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Value the device drives for bit k of frame f
    function automatic logic dev_bit(input int f, input int k);
        if (k < 8)       return logic'((f ^ k) & 1);
        else if (k == 8) return turn_a[f % MAXF];
        else             return data_a[f % MAXF][N-1-(k-9)];
    endfunction

    // Offer one frame and wait until it is taken
    task automatic send(input logic [7:0] c, input logic [N-1:0] d, input logic t);
        ctrl_a[nsent] = c;
        data_a[nsent] = d;
        turn_a[nsent] = t;
        req_word  = {c, ~t, d ^ N'(8'h3C)};
        req_valid = 1'b1;
        nsent++;
        while (1) begin
            if (req_ready) begin
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    // Drop the request and wait for the select to be released
    task automatic finish_burst();
        req_valid = 1'b0;
        @(negedge clk);
        while (!ss_n) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Device model and line monitor
    initial begin
        logic prev_ss = 1'b1;
        logic prev_sclk = 1'b0;
        logic first_rise = 1'b0;
        int k = 0, fr = 0, rfr = 0;
        int ss_fall_cyc = 0, last_rise = 0, last_rsp_cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (prev_ss && !ss_n) begin
                    chk("R7 oe at select", 32'(oe), 32'd1);
                    ss_fall_cyc = cyc;
                    first_rise = 1'b1;
                    k = 0;
                    sdi = dev_bit(fr, 0);
                end
                if (!prev_ss && ss_n) begin
                    ss_rises++;
                    chk("R10 select release delay", 32'(cyc - last_rsp_cyc), 32'(2*HALF));
                end
                if (!prev_sclk && sclk) begin
                    chk("R2 select low while clocking", 32'(ss_n), 32'd0);
                    if (first_rise)
                        chk("R2 first rise delay", 32'(cyc - ss_fall_cyc), 32'(HALF));
                    else
                        chk("R2 R9 bit period", 32'(cyc - last_rise), 32'(2*HALF));
                    first_rise = 1'b0;
                    last_rise = cyc;
                    if (k < 8) begin
                        chk("R3 control bit", 32'(sdo), 32'(ctrl_a[fr % MAXF][7-k]));
                        chk("R7 R9 oe in control", 32'(oe), 32'd1);
                    end else begin
                        chk("R4 quiet line", 32'(sdo), 32'd0);
                        chk("R7 oe off", 32'(oe), 32'd0);
                    end
                    k++;
                    if (k == W) begin
                        k = 0;
                        fr++;
                    end
                    sdi = dev_bit(fr, k);
                end
                if (rsp_valid) begin
                    chk("R6 response word", 32'(rsp_word),
                        32'({8'h00, turn_a[rfr % MAXF], data_a[rfr % MAXF]}));
                    chk("R5 control field zero", 32'(rsp_word[W-1:N+1]), 32'd0);
                    chk("R8 strobe at frame end", 32'(rfr), 32'(fr - 1));
                    rfr++;
                    last_rsp_cyc = cyc;
                end
            end
            prev_ss = ss_n;
            prev_sclk = sclk;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ss_n", 32'(ss_n), 32'd1);
        chk("R1 sclk", 32'(sclk), 32'd0);
        chk("R1 oe", 32'(oe), 32'd0);
        chk("R1 sdo", 32'(sdo), 32'd0);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 req_ready", 32'(req_ready), 32'd1);

        // Single frames with edge patterns
        send(8'h00, 8'h00, 1'b0); finish_burst();
        send(8'hFF, 8'hFF, 1'b1); finish_burst();
        send(8'hA5, 8'h5A, 1'b0); finish_burst();
        send(8'h5A, 8'hA5, 1'b1); finish_burst();
        send(8'h80, 8'h01, 1'b1); finish_burst();
        send(8'h01, 8'h80, 1'b0); finish_burst();

        // Back-to-back sweep of every control value
        for (int i = 0; i < 256; i++)
            send(8'(i), N'(i*37 + 5), logic'(i & 1));
        chk("R10 ready low after frame taken", 32'(req_ready), 32'd0);
        finish_burst();

        // Short chain
        send(8'h3C, 8'hC3, 1'b1);
        send(8'hC3, 8'h3C, 1'b0);
        send(8'h7E, 8'h81, 1'b1);
        finish_burst();

        chk("R9 select releases", 32'(ss_rises), 32'd8);
        chk("R8 all responses", 32'(nsent), 32'd265);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule